// File: doc/BRIEF.md
# Serial DAC Command Controller

This block is a serial-peripheral-bus master for a four-channel digital-to-analog converter that shares its bus with other devices. A client hands over a 4-bit command, a 4-bit channel address and a 12-bit value through a valid/ready handshake. The block packs these into a 32-bit frame and lowers the converter's active-low select. It then clocks the frame out most significant bit first and raises the select again, which starts the conversion.

While the frame goes out, the converter shifts back the complete word it received in the previous frame. The block samples that word on every rising serial clock edge, starting with the very first one. When the select has gone high, the block presents the word on a response port with a one-cycle strobe. The serial clock comes from a parameterised divider of the system clock. The block also drives fixed levels that keep the other devices on the bus inactive.

Top module: `dac_spi_ctrl`

## Requirements
- R1: After reset the select output is high, the serial clock is low, the request port is ready and the response strobe is low.
- R2: The 32-bit frame, from bit 31 down, is: eight zero bits, command (bits 23:20), channel address (bits 19:16), value (bits 15:4), four zero bits. It is shifted out most significant bit first, one bit per serial clock cycle.
- R3: The serial data output changes only while the serial clock is low. It never changes on the cycle the clock rises, nor while the clock is high.
- R4: Each frame has exactly 32 rising serial clock edges while the select is low. The select returns high only after the 32nd bit, on the falling edge that ends it.
- R5: Each serial clock half period lasts HALF_DIV system clocks. The first rising edge comes HALF_DIV clocks after the select falls, so a frame keeps the select low for 64*HALF_DIV clocks.
- R6: The returned word is made of the 32 input bits sampled on the 32 rising edges in order. The first sample, taken on the first rising edge, is bit 31.
- R7: The response strobe is high for exactly one clock, in the first cycle in which the select is high again, with the returned word valid in that cycle.
- R8: The serial clock is low whenever the select is high.
- R9: After a frame the block stays busy (not ready, select high) for 2*HALF_DIV clocks, counted from the response-strobe cycle, before it is ready again.
- R10: A request is taken only when ready is high. The valid level and field values presented while the block is busy start no frame and do not alter the frame in flight.
- R11: The bus-sharing outputs are held constant: serial flash select 1, pre-amplifier select 1, ADC convert 0, parallel flash enable 1, configuration PROM init 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle and able to take a request |
| reqCmd | input | 4 | Converter command nibble |
| reqAddr | input | 4 | Converter channel address |
| reqData | input | 12 | Conversion value |
| rspValid | output | 1 | One-cycle strobe: returned word valid |
| rspWord | output | 32 | Word shifted back by the converter |
| spiCsN | output | 1 | Converter select, active low |
| spiSck | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data to converter |
| spiMiso | input | 1 | Serial data from converter |
| romSelN | output | 1 | Serial flash select, held inactive (1) |
| preampSelN | output | 1 | Pre-amplifier select, held inactive (1) |
| adcConvert | output | 1 | ADC convert strobe, held inactive (0) |
| norFlashCeN | output | 1 | Parallel flash enable, held inactive (1) |
| cfgRomInitN | output | 1 | Configuration PROM init, held at 1 |

## Verification
Some rules are checked on every cycle: the serial data stays still around and during the high clock phase, the clock is low whenever the select is high, each half period has its exact length, and every frame has exactly 32 rising edges. Further cycle-by-cycle checks cover the one-cycle response strobe tied to the select's rise, the minimum select-high gap, and the busy state that follows an accepted request. Only the bench's scenarios can show the bit content. These checks cover that the converter model receives the exact packed frame, that each returned word is the previous frame (or the model's power-up word), and that requests held during a frame leave it unchanged and start nothing.

// File: rtl/dac_spi_pkg.sv
package dac_spi_pkg;
  localparam int FRAME_W  = 32;
  localparam int CMD_W    = 4;
  localparam int ADDR_W   = 4;
  localparam int VAL_W    = 12;
  localparam int TAIL_PAD = 4;
  localparam int HEAD_PAD = FRAME_W - CMD_W - ADDR_W - VAL_W - TAIL_PAD;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic sample;
    logic shift;
    logic finish;
  } dpStrobe_t;
endpackage

// File: rtl/dac_spi_ctrl_fsm.sv
module dac_spi_ctrl_fsm
  import dac_spi_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output dpStrobe_t  strobe,
  output logic       spiCsN,
  output logic       spiSck
);
  localparam int TW = (2 * HALF_DIV > 2) ? $clog2(2 * HALF_DIV) : 1;
  localparam int BW = $clog2(FRAME_W);
  localparam logic [TW-1:0] HALF_RELOAD = TW'(HALF_DIV - 1);
  localparam logic [TW-1:0] GAP_RELOAD  = TW'(2 * HALF_DIV - 1);
  localparam logic [BW-1:0] LAST_BIT    = BW'(FRAME_W - 1);

  ctrlState_t state;
  logic [TW-1:0] timer;
  logic [BW-1:0] bitCnt;
  logic tick;
  logic lastBit;

  assign tick     = (timer == '0);
  assign lastBit  = (bitCnt == LAST_BIT);
  assign reqReady = (state == ST_IDLE);

  always_comb begin
    strobe.load   = (state == ST_IDLE) && reqValid;
    strobe.sample = (state == ST_SHIFT) && tick && !spiSck;
    strobe.shift  = (state == ST_SHIFT) && tick && spiSck && !lastBit;
    strobe.finish = (state == ST_SHIFT) && tick && spiSck && lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      timer  <= '0;
      bitCnt <= '0;
      spiCsN <= 1'b1;
      spiSck <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state  <= ST_SHIFT;
            spiCsN <= 1'b0;
            spiSck <= 1'b0;
            timer  <= HALF_RELOAD;
            bitCnt <= '0;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            timer  <= HALF_RELOAD;
            spiSck <= !spiSck;
            if (spiSck) begin
              if (lastBit) begin
                spiCsN <= 1'b1;
                state  <= ST_GAP;
                timer  <= GAP_RELOAD;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end else begin
            timer <= timer - 1'b1;
          end
        end
        ST_GAP: begin
          if (tick) state <= ST_IDLE;
          else      timer <= timer - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dac_spi_datapath.sv
module dac_spi_datapath
  import dac_spi_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [CMD_W-1:0]   reqCmd,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [VAL_W-1:0]   reqData,
  input  logic               spiMiso,
  output logic               spiMosi,
  output logic               rspValid,
  output logic [FRAME_W-1:0] rspWord
);
  logic [FRAME_W-1:0] txShift;
  logic [FRAME_W-1:0] rxShift;
  logic [FRAME_W-1:0] frameWord;

  assign frameWord = {{HEAD_PAD{1'b0}}, reqCmd, reqAddr, reqData, {TAIL_PAD{1'b0}}};
  assign spiMosi   = txShift[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift  <= '0;
      rxShift  <= '0;
      rspWord  <= '0;
      rspValid <= 1'b0;
    end else begin
      rspValid <= strobe.finish;
      if (strobe.load)   txShift <= frameWord;
      if (strobe.shift)  txShift <= {txShift[FRAME_W-2:0], 1'b0};
      if (strobe.sample) rxShift <= {rxShift[FRAME_W-2:0], spiMiso};
      if (strobe.finish) rspWord <= rxShift;
    end
  end
endmodule

// File: rtl/dac_spi_ctrl.sv
module dac_spi_ctrl
  import dac_spi_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [3:0]  reqCmd,
  input  logic [3:0]  reqAddr,
  input  logic [11:0] reqData,
  output logic        rspValid,
  output logic [31:0] rspWord,
  output logic        spiCsN,
  output logic        spiSck,
  output logic        spiMosi,
  input  logic        spiMiso,
  output logic        romSelN,
  output logic        preampSelN,
  output logic        adcConvert,
  output logic        norFlashCeN,
  output logic        cfgRomInitN
);
  dpStrobe_t strobe;

  // keep the neighbours on the shared bus inactive
  assign romSelN     = 1'b1;
  assign preampSelN  = 1'b1;
  assign adcConvert  = 1'b0;
  assign norFlashCeN = 1'b1;
  assign cfgRomInitN = 1'b1;

  dac_spi_ctrl_fsm #(.HALF_DIV(HALF_DIV)) u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .strobe   (strobe),
    .spiCsN   (spiCsN),
    .spiSck   (spiSck)
  );

  dac_spi_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqCmd   (reqCmd),
    .reqAddr  (reqAddr),
    .reqData  (reqData),
    .spiMiso  (spiMiso),
    .spiMosi  (spiMosi),
    .rspValid (rspValid),
    .rspWord  (rspWord)
  );
endmodule

// File: rtl/dac_spi_checker.sv
module dac_spi_checker #(
  parameter int HALF_DIV = 2
) (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic rspValid,
  input logic spiCsN,
  input logic spiSck,
  input logic spiMosi
);
  localparam int CW = $clog2(4 * HALF_DIV + 2) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic sckQ, csQ;
  logic [CW-1:0] sinceEvt;
  logic [CW-1:0] highCnt;
  logic [6:0] riseCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckQ     <= 1'b0;
      csQ      <= 1'b1;
      sinceEvt <= CMAX;
      highCnt  <= CMAX;
      riseCnt  <= '0;
    end else begin
      sckQ <= spiSck;
      csQ  <= spiCsN;
      if ((spiSck != sckQ) || (spiCsN != csQ)) sinceEvt <= CW'(1);
      else if (sinceEvt != CMAX)               sinceEvt <= sinceEvt + 1'b1;
      if (!spiCsN)               highCnt <= '0;
      else if (highCnt != CMAX)  highCnt <= highCnt + 1'b1;
      if (spiCsN && csQ)                   riseCnt <= '0;
      else if (spiSck && !sckQ && !spiCsN) riseCnt <= riseCnt + 1'b1;
    end
  end

  a_r1_ready_when_select_idle: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady |-> spiCsN));
  a_r3_mosi_still_at_rise: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(spiSck) |-> $stable(spiMosi)));
  a_r3_mosi_still_while_high: assert property (@(posedge clk) disable iff (!rstN)
    ((spiSck && $past(spiSck)) |-> $stable(spiMosi)));
  a_r4_thirty_two_rises: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(spiCsN) |-> (riseCnt == 7'd32)));
  a_r5_half_period_len: assert property (@(posedge clk) disable iff (!rstN)
    ((!spiCsN && (spiSck != sckQ)) |-> (sinceEvt == CW'(HALF_DIV))));
  a_r7_strobe_on_select_rise: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(spiCsN) |-> rspValid));
  a_r7_strobe_only_then: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid |-> $rose(spiCsN)));
  a_r8_clock_low_when_deselected: assert property (@(posedge clk) disable iff (!rstN)
    (spiCsN |-> !spiSck));
  a_r9_min_select_high: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(spiCsN) |-> (highCnt >= CW'(2 * HALF_DIV))));
  a_r10_accept_starts_frame: assert property (@(posedge clk) disable iff (!rstN)
    ((reqValid && reqReady) |=> (!spiCsN && !reqReady)));
endmodule

bind dac_spi_ctrl dac_spi_checker #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .rspValid (rspValid),
  .spiCsN   (spiCsN),
  .spiSck   (spiSck),
  .spiMosi  (spiMosi)
);

// File: tb/dac_spi_ctrl_bench.sv
module dac_spi_ctrl_bench;
  localparam int HALF = 2;
  localparam logic [31:0] POWERUP_WORD = 32'hC3A5_5A3C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [3:0] reqCmd = '0;
  logic [3:0] reqAddr = '0;
  logic [11:0] reqData = '0;
  logic rspValid;
  logic [31:0] rspWord;
  logic spiCsN, spiSck, spiMosi;
  logic spiMiso = 1'b0;
  logic romSelN, preampSelN, adcConvert, norFlashCeN, cfgRomInitN;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [31:0] expFrame[$];
  logic [31:0] expEcho[$];
  logic [31:0] lastSent = POWERUP_WORD;
  int sentCnt = 0;

  always #5 clk = ~clk;

  dac_spi_ctrl #(.HALF_DIV(HALF)) u_dac_spi_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqCmd(reqCmd), .reqAddr(reqAddr), .reqData(reqData),
    .rspValid(rspValid), .rspWord(rspWord),
    .spiCsN(spiCsN), .spiSck(spiSck), .spiMosi(spiMosi), .spiMiso(spiMiso),
    .romSelN(romSelN), .preampSelN(preampSelN), .adcConvert(adcConvert),
    .norFlashCeN(norFlashCeN), .cfgRomInitN(cfgRomInitN)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] packFrame(input logic [3:0] c, input logic [3:0] a, input logic [11:0] d);
    return {8'h00, c, a, d, 4'h0};
  endfunction

  // driver: wait for ready, hand over one request, record expectations
  task automatic send(input logic [3:0] c, input logic [3:0] a, input logic [11:0] d);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqCmd = c; reqAddr = a; reqData = d;
    expFrame.push_back(packFrame(c, a, d));
    expEcho.push_back(lastSent);
    lastSent = packFrame(c, a, d);
    sentCnt++;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // converter model
  logic [31:0] slavePrev = POWERUP_WORD;
  logic [31:0] slaveCapt = '0;
  int slaveIn = 0;
  int slaveOut = 0;
  int slaveFrames = 0;
  bit frameOpen = 0;

  always @(negedge spiCsN) begin
    frameOpen = 1;
    slaveIn = 0;
    slaveOut = 31;
    spiMiso = slavePrev[31];
  end
  always @(posedge spiSck) if (!spiCsN) begin
    slaveCapt = {slaveCapt[30:0], spiMosi};
    slaveIn++;
  end
  always @(negedge spiSck) if (!spiCsN && slaveOut > 0) begin
    slaveOut--;
    spiMiso = slavePrev[slaveOut];
  end
  always @(posedge spiCsN) if (frameOpen) begin
    logic [31:0] e;
    frameOpen = 0;
    slaveFrames++;
    chk(slaveIn == 32, "R4 rising edges per frame", slaveIn, 32);
    e = (expFrame.size() > 0) ? expFrame.pop_front() : 32'hxxxx_xxxx;
    chk(slaveCapt === e, "R2 frame received by converter", slaveCapt, e);
    slavePrev = slaveCapt;
  end

  // monitor: timing and response scoreboard, sampled at negedge
  int lowCnt = 0;
  int gapCnt = -1;
  int strobeRun = 0;
  int mosiViol = 0;
  int sckViol = 0;
  int busyReadyViol = 0;
  logic sckPrev = 1'b0;
  logic mosiPrev = 1'b0;

  always @(negedge clk) if (rstN) begin
    if (spiSck && sckPrev && (spiMosi !== mosiPrev)) mosiViol++;
    if (spiSck && !sckPrev && (spiMosi !== mosiPrev)) mosiViol++;
    if (spiCsN && spiSck) sckViol++;
    if (!spiCsN && reqReady) busyReadyViol++;
    sckPrev = spiSck;
    mosiPrev = spiMosi;

    if (!spiCsN) lowCnt++;
    else if (lowCnt != 0) begin
      chk(lowCnt == 64 * HALF, "R5 select low duration", lowCnt, 64 * HALF);
      lowCnt = 0;
    end

    if (rspValid) begin
      logic [31:0] e;
      strobeRun++;
      chk(spiCsN === 1'b1, "R7 select high at strobe", spiCsN, 1);
      e = (expEcho.size() > 0) ? expEcho.pop_front() : 32'hxxxx_xxxx;
      chk(rspWord === e, "R6 returned word", rspWord, e);
      gapCnt = 1;
    end else begin
      if (strobeRun != 0) chk(strobeRun == 1, "R7 strobe width", strobeRun, 1);
      strobeRun = 0;
      if (gapCnt > 0) begin
        if (reqReady) begin
          chk(gapCnt == 2 * HALF, "R9 busy cycles after frame", gapCnt, 2 * HALF);
          gapCnt = -1;
        end else gapCnt++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(spiCsN === 1'b1, "R1 select after reset", spiCsN, 1);
    chk(spiSck === 1'b0, "R1 clock after reset", spiSck, 0);
    chk(reqReady === 1'b1, "R1 ready after reset", reqReady, 1);
    chk(rspValid === 1'b0, "R1 strobe after reset", rspValid, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(reqReady === 1'b1 && spiCsN === 1'b1, "R1 idle after release", {reqReady, spiCsN}, 2'b11);

    send(4'h3, 4'h0, 12'hABC);
    // R10: noise while busy must start nothing nor alter the frame in flight
    repeat (20) begin
      @(negedge clk);
      reqValid = 1'b1; reqCmd = 4'h9; reqAddr = 4'h6; reqData = 12'h555;
    end
    @(negedge clk);
    reqValid = 1'b0;
    send(4'hF, 4'hF, 12'hFFF);
    send(4'h0, 4'h1, 12'h000);
    send(4'h2, 4'h5, 12'h5A5);
    send(4'h3, 4'hA, 12'h800);
    repeat (7) @(negedge clk);
    send(4'h1, 4'h2, 12'h001);
    send(4'h3, 4'hF, 12'h7FE);

    @(negedge clk);
    while (!(reqReady && expEcho.size() == 0)) @(negedge clk);
    repeat (10) @(negedge clk);

    chk(slaveFrames == sentCnt, "R10 frames started equal requests", slaveFrames, sentCnt);
    chk(busyReadyViol == 0, "R10 ready while busy", busyReadyViol, 0);
    chk(mosiViol == 0, "R3 data change near rising edge", mosiViol, 0);
    chk(sckViol == 0, "R8 clock high while deselected", sckViol, 0);
    chk({romSelN, preampSelN, adcConvert, norFlashCeN, cfgRomInitN} === 5'b11011,
        "R11 bus-sharing levels", {romSelN, preampSelN, adcConvert, norFlashCeN, cfgRomInitN}, 5'b11011);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule